// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 65,536 words by 16 bits. The RAM has an active-low chip select, write strobe, output enable and one active-low enable per byte lane. Each accepted request becomes one complete bus cycle on the memory pins. Every timing window of that cycle is a whole number of clock cycles, derived at elaboration from nanosecond parameters: each is the ceiling of the time divided by the clock period, and never less than one cycle.

A write is controlled by the write strobe. Chip select and the lane enables fall one set-up window before the strobe, the strobe stays low for the pulse window, and a recovery window stretches the cycle to the minimum write cycle time. A read holds chip select and output enable low for the longer of the address-access and output-enable-access delays, then samples the bus in one more cycle. Lanes whose mask bit is clear are never strobed and read back as zero. The controller drives the data bus only in write states. A write that directly follows a read first waits with the bus released until the device's output driver is off.

Address, write data and lane mask are registered on acceptance, so the user side may change them freely while the cycle runs. A request with an empty lane mask starts no bus cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is active and in every idle cycle, `req_ready` is 1 and chip select, write strobe, output enable and all lane enables are high (inactive). During reset `mem_dq_oe` and `rsp_valid` are 0.
- R2: In a write, chip select and the selected lane enables go low one set-up cycle before `mem_we_n` falls. `mem_we_n` then stays low for at least ceil(55 ns / period) cycles (6 at 10 ns). `mem_dq_out` is driven, and held unchanged, from set-up to the end of the pulse, which covers at least ceil(35 ns / period) cycles.
- R3: A write keeps `req_ready` low for set-up + pulse + recovery cycles. Recovery is stretched so that the total reaches ceil(85 ns / period); at the default parameters the total is 9 cycles.
- R4: Mask bit 0 selects data bits 7:0 and lane enable `mem_lane_n[0]`, and mask bit 1 selects bits 15:8 and `mem_lane_n[1]`. A lane whose mask bit is 0 keeps its enable high and its stored byte is unchanged.
- R5: A read holds chip select and `mem_oe_n` low with `mem_we_n` high for max(ceil(85/period), ceil(40/period)) cycles, then for one capture cycle, at whose closing edge the bus is sampled. `req_ready` is low for 10 cycles at defaults, and `rsp_valid` is high for one cycle right after, with the data on `rsp_rdata`.
- R6: In `rsp_rdata`, the bits of a lane whose mask bit was 0 are zero.
- R7: A request with mask 00 is accepted without any bus cycle. A read with mask 00 answers on the next cycle with data zero, and a write with mask 00 changes no stored data.
- R8: `mem_dq_oe` is high only in write states, only while `mem_oe_n` is high, and never while the device may still be driving the bus.
- R9: A write accepted directly after a read waits ceil(30 ns / period) cycles (3 at defaults) with every strobe high and the bus released before its set-up cycle. The same write accepted after another write does not wait.
- R10: Address, data and mask are registered on acceptance. `mem_addr` stays stable for as long as chip select is low, whatever the request inputs do during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | LANES | Active-high lane select, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | LANES | Byte lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data returned from the memory |

## Verification
The bench runs full-width writes and reads, single-lane writes on top of earlier full-width data, and single-lane reads, so that a lane decode error or a swapped lane shows up as a wrong merged word. Writes are issued both directly after a read and directly after another write. The first must show the turnaround wait and the second must not, which tells a correct turnaround apart from one that is always or never inserted. Empty-mask reads and writes, accesses at the top address, and request inputs scrambled right after acceptance check that nothing leaks onto the pins. The behavioural memory model returns garbage until the access time has passed and keeps driving for the release time after output enable rises, so that early capture or bus contention becomes visible.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_ACC   = 3'd1,
      ST_RD_CAP   = 3'd2,
      ST_TURN     = 3'd3,
      ST_WR_SET   = 3'd4,
      ST_WR_PULSE = 3'd5,
      ST_WR_REC   = 3'd6
   } ctrl_state_t;

   // whole clock cycles covering a time, at least one
   function automatic int ns_to_cyc(input int ns, input int period_ns);
      int c;
      c = (ns + period_ns - 1) / period_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_win_timer.sv
module sram_win_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic [LANES-1:0]  in_mask,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_wdata,
   output logic [LANES-1:0]  lat_mask
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_mask  <= '0;
      end else if (load) begin
         lat_addr  <= in_addr;
         lat_wdata <= in_wdata;
         lat_mask  <= in_mask;
      end
   end

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  ctrl_state_t       st,
   input  logic [ADDR_W-1:0] lat_addr,
   input  logic [DATA_W-1:0] lat_wdata,
   input  logic [LANES-1:0]  lat_mask,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_lane_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe
);

   logic sel;
   logic rd_phase;
   logic wr_phase;

   always_comb begin
      rd_phase = (st == ST_RD_ACC) || (st == ST_RD_CAP);
      wr_phase = (st == ST_WR_SET) || (st == ST_WR_PULSE) || (st == ST_WR_REC);
      sel      = rd_phase || (st == ST_WR_SET) || (st == ST_WR_PULSE);
   end

   assign mem_addr   = lat_addr;
   assign mem_cs_n   = !sel;
   assign mem_oe_n   = !rd_phase;
   assign mem_we_n   = (st != ST_WR_PULSE);
   assign mem_dq_out = lat_wdata;
   assign mem_dq_oe  = wr_phase;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign mem_lane_n[g] = !(sel && lat_mask[g]);
   end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              clr,
   input  logic [LANES-1:0]  lat_mask,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] keep;

   for (genvar g = 0; g < LANES; g++) begin : g_keep
      assign keep[g*8 +: 8] = {8{lat_mask[g]}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (cap_en)
         rdata <= dq_in & keep;
      else if (clr)
         rdata <= '0;
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int CLK_NS    = 10,
   parameter int T_AA_NS   = 85,
   parameter int T_OEA_NS  = 40,
   parameter int T_WC_NS   = 85,
   parameter int T_WP_NS   = 55,
   parameter int T_AS_NS   = 0,
   parameter int T_WR_NS   = 0,
   parameter int T_DW_NS   = 35,
   parameter int T_HZ_NS   = 30,
   localparam int LANES    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_lane_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   // window lengths in cycles
   localparam int N_AA     = ns_to_cyc(T_AA_NS, CLK_NS);
   localparam int N_OEA    = ns_to_cyc(T_OEA_NS, CLK_NS);
   localparam int N_RD     = max_i(N_AA, N_OEA);
   localparam int N_AS     = ns_to_cyc(T_AS_NS, CLK_NS);
   localparam int N_WP     = ns_to_cyc(T_WP_NS, CLK_NS);
   localparam int N_DW     = ns_to_cyc(T_DW_NS, CLK_NS);
   localparam int N_DW_REM = (N_DW > N_AS) ? (N_DW - N_AS) : 1;
   localparam int N_PULSE  = max_i(N_WP, N_DW_REM);
   localparam int N_WC     = ns_to_cyc(T_WC_NS, CLK_NS);
   localparam int N_WR     = ns_to_cyc(T_WR_NS, CLK_NS);
   localparam int N_FILL   = (N_WC > N_AS + N_PULSE) ? (N_WC - N_AS - N_PULSE) : 1;
   localparam int N_REC    = max_i(N_WR, N_FILL);
   localparam int N_TA     = ns_to_cyc(T_HZ_NS, CLK_NS);
   localparam int CNT_MAX  = max_i(max_i(N_RD, N_PULSE), max_i(max_i(N_REC, N_TA), N_AS));
   localparam int CW       = $clog2(CNT_MAX + 1);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("sram_lane_ctrl: DATA_W must be a non-zero multiple of 8");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_lane_ctrl: CLK_NS must be positive");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sram_lane_ctrl: ADDR_W must be positive");
   end

   ctrl_state_t       st_q, st_d;
   logic              tmr_load;
   logic [CW-1:0]     tmr_val;
   logic              tmr_zero;
   logic              last_rd_q;
   logic              rsp_q;
   logic              accept;
   logic              mask_any;
   logic              empty_rd;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic [LANES-1:0]  lat_mask;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign mask_any  = |req_mask;
   assign empty_rd  = accept && !mask_any && !req_we;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (st_q)
         ST_IDLE: begin
            if (accept && mask_any) begin
               tmr_load = 1'b1;
               if (!req_we) begin
                  st_d    = ST_RD_ACC;
                  tmr_val = CW'(N_RD - 1);
               end else if (last_rd_q) begin
                  st_d    = ST_TURN;
                  tmr_val = CW'(N_TA - 1);
               end else begin
                  st_d    = ST_WR_SET;
                  tmr_val = CW'(N_AS - 1);
               end
            end
         end
         ST_RD_ACC: begin
            if (tmr_zero) begin
               st_d     = ST_RD_CAP;
               tmr_load = 1'b1;
            end
         end
         ST_RD_CAP: begin
            st_d = ST_IDLE;
         end
         ST_TURN: begin
            if (tmr_zero) begin
               st_d     = ST_WR_SET;
               tmr_load = 1'b1;
               tmr_val  = CW'(N_AS - 1);
            end
         end
         ST_WR_SET: begin
            if (tmr_zero) begin
               st_d     = ST_WR_PULSE;
               tmr_load = 1'b1;
               tmr_val  = CW'(N_PULSE - 1);
            end
         end
         ST_WR_PULSE: begin
            if (tmr_zero) begin
               st_d     = ST_WR_REC;
               tmr_load = 1'b1;
               tmr_val  = CW'(N_REC - 1);
            end
         end
         ST_WR_REC: begin
            if (tmr_zero)
               st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         last_rd_q <= 1'b0;
         rsp_q     <= 1'b0;
      end else begin
         st_q  <= st_d;
         rsp_q <= (st_q == ST_RD_CAP) || empty_rd;
         if (st_q == ST_RD_CAP)
            last_rd_q <= 1'b1;
         else if (st_q == ST_WR_SET)
            last_rd_q <= 1'b0;
      end
   end

   assign rsp_valid = rsp_q;

   sram_win_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .in_addr   (req_addr),
      .in_wdata  (req_wdata),
      .in_mask   (req_mask),
      .lat_addr  (lat_addr),
      .lat_wdata (lat_wdata),
      .lat_mask  (lat_mask)
   );

   sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
      .st         (st_q),
      .lat_addr   (lat_addr),
      .lat_wdata  (lat_wdata),
      .lat_mask   (lat_mask),
      .mem_addr   (mem_addr),
      .mem_cs_n   (mem_cs_n),
      .mem_we_n   (mem_we_n),
      .mem_oe_n   (mem_oe_n),
      .mem_lane_n (mem_lane_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe)
   );

   sram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (st_q == ST_RD_CAP),
      .clr      (empty_rd),
      .lat_mask (lat_mask),
      .dq_in    (mem_dq_in),
      .rdata    (rsp_rdata)
   );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int LANES     = 2,
   parameter int PULSE_MIN = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [LANES-1:0]  mem_lane_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   logic [15:0] wlow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wlow_q <= '0;
      else if (!mem_we_n)
         wlow_q <= (wlow_q == 16'hFFFF) ? wlow_q : wlow_q + 16'd1;
      else
         wlow_q <= '0;
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));

   p_we_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_oe_n));

   p_wdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

   p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (32'(wlow_q) >= PULSE_MIN));

   p_lane_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> (mem_lane_n != '1));

   p_rsp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);

   p_no_fight_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .LANES     (LANES),
   .PULSE_MIN (N_PULSE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_addr   (mem_addr),
   .mem_cs_n   (mem_cs_n),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_lane_n (mem_lane_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int WP_MIN     = (55 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int DW_MIN     = (35 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int RD_VALID   = (85 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int HZ_CYC     = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int WR_BUSY    = 9;
   localparam int RD_BUSY    = 10;
   localparam int TA_CYC     = 3;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_we = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [15:0] mem_addr;
   logic        mem_cs_n, mem_we_n, mem_oe_n;
   logic [1:0]  mem_lane_n;
   logic [15:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_in = 16'h5A5A;

   int errors = 0;
   int checks = 0;
   bit prev_rd = 1'b0;
   logic [15:0] exp_mem [int];
   logic [15:0] dev_mem [int];

   always #(CLK_PERIOD / 2) clk = ~clk;

   sram_lane_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] rd_word(input logic [15:0] a, input bit dev);
      if (dev) return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : 16'h0000;
      return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0000;
   endfunction

   // behavioural memory device, observed every cycle
   int          rd_cnt = 0, wp_cnt = 0, dst_cnt = 0, dst_last = 0, hold = 0;
   bit          wr_act_q = 1'b0, prev_cs_n = 1'b1, prev_oe = 1'b0;
   logic [15:0] rd_addr_q, cs_addr_q, dq_prev, wr_addr_q, wr_data_q;
   logic [1:0]  wr_lane_q;

   always @(negedge clk) begin
      if (rst_n) begin
         bit rd_act, wr_act;
         logic [15:0] w;
         rd_act = !mem_cs_n && !mem_oe_n && mem_we_n && (mem_lane_n != 2'b11);
         wr_act = !mem_cs_n && !mem_we_n && (mem_lane_n != 2'b11);
         if (rd_act) begin
            rd_cnt = (rd_cnt == 0 || mem_addr == rd_addr_q) ? rd_cnt + 1 : 1;
            rd_addr_q = mem_addr;
         end else rd_cnt = 0;
         w = rd_word(mem_addr, 1'b1);
         if (rd_act && rd_cnt >= RD_VALID)
            mem_dq_in = {mem_lane_n[1] ? 8'hC3 : w[15:8], mem_lane_n[0] ? 8'hC3 : w[7:0]};
         else
            mem_dq_in = 16'h5A5A;
         if (!mem_cs_n && !prev_cs_n)
            chk(mem_addr == cs_addr_q, "R10", "address moved under chip select", 32'(mem_addr), 32'(cs_addr_q));
         if (!mem_cs_n) cs_addr_q = mem_addr;
         if (mem_dq_oe) begin
            dst_cnt = (prev_oe && mem_dq_out == dq_prev) ? dst_cnt + 1 : 1;
            dq_prev = mem_dq_out;
         end else dst_cnt = 0;
         if (wr_act) begin
            if (!wr_act_q) begin
               wp_cnt = 0;
               chk(!prev_cs_n, "R2", "chip select before strobe", 32'(prev_cs_n), 32'd0);
            end
            wp_cnt++;
            dst_last  = dst_cnt;
            wr_addr_q = mem_addr;
            wr_data_q = mem_dq_out;
            wr_lane_q = mem_lane_n;
         end else if (wr_act_q) begin
            chk(wp_cnt >= WP_MIN, "R2", "write pulse cycles", 32'(wp_cnt), 32'(WP_MIN));
            chk(dst_last >= DW_MIN, "R2", "data stable cycles", 32'(dst_last), 32'(DW_MIN));
            w = rd_word(wr_addr_q, 1'b1);
            if (!wr_lane_q[0]) w[7:0]  = wr_data_q[7:0];
            if (!wr_lane_q[1]) w[15:8] = wr_data_q[15:8];
            dev_mem[int'(wr_addr_q)] = w;
         end
         if (rd_act) hold = HZ_CYC;
         else if (hold > 0) hold--;
         if (mem_dq_oe)
            chk(!rd_act && hold == 0, "R8", "bus driven while device drives", 32'(hold), 32'd0);
         wr_act_q  = wr_act;
         prev_cs_n = mem_cs_n;
         prev_oe   = mem_dq_oe;
      end
   end

   // one request; called and returns at a negative edge
   task automatic do_req(input bit we, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
      int busy;
      bit turn;
      logic [15:0] e;
      chk(req_ready == 1'b1, "R1", "ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_mask = ~m;   // R10 scramble
      turn = we && (m != 2'b00) && prev_rd;
      if (m == 2'b00) busy = 0;
      else if (we) busy = (turn ? TA_CYC : 0) + WR_BUSY;
      else busy = RD_BUSY;
      for (int k = 0; k < busy; k++) begin
         chk(req_ready == 1'b0, we ? "R3" : "R5", "ready low while busy", 32'(req_ready), 32'd0);
         chk(rsp_valid == 1'b0, "R5", "no response while busy", 32'(rsp_valid), 32'd0);
         if (turn && k < TA_CYC)
            chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R9", "turnaround quiet",
                {28'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'he);
         if (!we && m != 2'b00)
            chk(mem_lane_n == ~m, "R4", "lane enables in read", 32'(mem_lane_n), 32'(~m));
         @(negedge clk);
      end
      chk(req_ready == 1'b1, we ? "R3" : "R5", "ready back after cycle", 32'(req_ready), 32'd1);
      if (!we) begin
         e = rd_word(a, 1'b0);
         e = {m[1] ? e[15:8] : 8'h00, m[0] ? e[7:0] : 8'h00};
         chk(rsp_valid == 1'b1, m == 2'b00 ? "R7" : "R5", "response strobe", 32'(rsp_valid), 32'd1);
         chk(rsp_rdata == e, m == 2'b11 ? "R5" : (m == 2'b00 ? "R7" : "R6"), "read data",
             32'(rsp_rdata), 32'(e));
      end else begin
         chk(rsp_valid == 1'b0, "R7", "no response to write", 32'(rsp_valid), 32'd0);
         if (m != 2'b00) begin
            e = rd_word(a, 1'b0);
            if (m[0]) e[7:0]  = d[7:0];
            if (m[1]) e[15:8] = d[15:8];
            exp_mem[int'(a)] = e;
         end
      end
      if (m != 2'b00) prev_rd = !we;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && mem_cs_n && mem_we_n && mem_oe_n && (mem_lane_n == 2'b11) && !mem_dq_oe && !rsp_valid,
          "R1", "reset state", {25'd0, req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe}, 32'h7e);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && mem_cs_n && (mem_lane_n == 2'b11), "R1", "idle after reset",
          {29'd0, req_ready, mem_cs_n, mem_lane_n == 2'b11}, 32'd7);

      do_req(1'b1, 16'h0010, 16'h1234, 2'b11);   // R2 R3 full write
      do_req(1'b0, 16'h0010, 16'h0000, 2'b11);   // R5 full read
      do_req(1'b1, 16'h0010, 16'hABCD, 2'b10);   // R9 write right after read, R4 upper only
      do_req(1'b1, 16'h0011, 16'h5566, 2'b11);   // write after write, no turnaround
      do_req(1'b0, 16'h0010, 16'h0000, 2'b11);   // R4 merged word 0xAB34
      do_req(1'b0, 16'h0010, 16'h0000, 2'b01);   // R6 lower only
      do_req(1'b0, 16'h0010, 16'h0000, 2'b10);   // R6 upper only
      do_req(1'b1, 16'hFFFF, 16'h99EE, 2'b01);   // top address, lower lane
      do_req(1'b0, 16'hFFFF, 16'h0000, 2'b11);
      do_req(1'b1, 16'h0010, 16'hFFFF, 2'b00);   // R7 empty write
      chk(mem_cs_n, "R7", "no strobe for empty write", 32'(mem_cs_n), 32'd1);
      do_req(1'b0, 16'h0010, 16'h0000, 2'b11);   // R7 data unchanged
      do_req(1'b0, 16'h0011, 16'h0000, 2'b00);   // R7 empty read answers zero
      for (int i = 0; i < 6; i++)
         do_req(1'b1, 16'h0100 + 16'(i), 16'hC000 ^ 16'(i * 16'h0111), (i % 3 == 0) ? 2'b01 : 2'b11);
      for (int i = 0; i < 6; i++)
         do_req(1'b0, 16'h0100 + 16'(i), 16'h0000, 2'b11);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule